// File: doc/BRIEF.md
# Hierarchical State-Enable Register Bank

This block holds the state-enable control registers for three privilege levels of a RISC-V-style core: four 64-bit machine copies, four hypervisor copies and four supervisor copies. The core's CSR unit presents one request per cycle: a 12-bit CSR address, a read or write flag, write data, the current privilege and the virtualization flag. The bank answers in the same cycle with a hit flag, an illegal-instruction flag and read data. A legal write updates the addressed register at the next rising clock edge.

Writes go down the privilege chain. A machine copy can change only the bits in its writable-field mask. A hypervisor copy can also change only the bits that the matching machine copy currently holds at one. A supervisor copy is further limited by the matching hypervisor copy while virtualization is active. On a 32-bit core, the upper word of the machine and hypervisor copies has its own address. The current contents of all twelve registers are driven out as enable vectors for the resources they gate.

Top module: `stateen_bank`

## Requirements
- R1: Address decode uses the low two address bits as the register index. Machine copies are at 0x30C..0x30F and their upper words at 0x31C..0x31F. Hypervisor copies are at 0x60C..0x60F and their upper words at 0x61C..0x61F. Supervisor copies are at 0x10C..0x10F. Any other address, including 0x11C..0x11F, gives hit=0, illegal=0 and read data 0.
- R2: After reset, all twelve registers read zero on the enable-vector outputs.
- R3: While `feat_en` is low, every access to a mapped address raises illegal and changes no register.
- R4: Privilege encoding is 2'b11 machine, 2'b01 supervisor and 2'b00 user. Machine copies are legal only in machine mode. Hypervisor copies are legal in machine mode, or in supervisor mode with `virt` low. Supervisor copies are legal in machine or supervisor mode, whatever `virt` is. Every other combination raises illegal.
- R5: A register changes only on a legal write with `req_valid` high. A machine-copy write follows new = (old & ~M) | (data & M), where M is `WMASK` entry [index].
- R6: A hypervisor-copy write uses M = `WMASK`[index] & the machine copy [index].
- R7: A supervisor-copy write uses M = `WMASK`[index] & ~bit63 & the machine copy [index]. While `virt` is high, M is also ANDed with the hypervisor copy [index]. Bit 63 of every supervisor copy therefore stays 0.
- R8: An upper-word write stores data[31:0] into bits 63:32 and leaves bits 31:0 unchanged. An upper-word read returns bits 63:32 in rdata[31:0], with rdata[63:32] zero.
- R9: With `IS_RV32`=1, a lower-word write changes only bits 31:0, and a read returns bits 31:0 zero-extended. With `IS_RV32`=0, lower-word accesses cover all 64 bits.
- R10: With `IS_RV32`=0, upper-word addresses raise illegal and change nothing.
- R11: An illegal access returns read data 0 and modifies no register.
- R12: Read data comes combinationally from the current contents: the read data of a write shows the value held before that write. The enable vectors show a write from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_en | input | 1 | State-enable feature present/enabled |
| priv | input | 2 | Current privilege (11 M, 01 S, 00 U) |
| virt | input | 1 | Virtualization mode active |
| req_valid | input | 1 | CSR request valid this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | CSR address |
| req_wdata | input | 64 | Write data (low 32 bits used for 32-bit accesses) |
| rsp_hit | output | 1 | Address belongs to this bank (with req_valid) |
| rsp_illegal | output | 1 | Illegal-instruction indication |
| rsp_rdata | output | 64 | Read data, zero when illegal or no hit |
| m_en | output | 256 | Machine copies, index i at bits [64i+63:64i] |
| h_en | output | 256 | Hypervisor copies, same packing |
| s_en | output | 256 | Supervisor copies, same packing |

## Verification
A bad write mask shows up on the enable-vector outputs one cycle after the write. It appears either as a bit that lands in a lower-level copy although its higher-level copy is clear, or as a bit that changes outside the writable field. A wrong half-select or a wrong index corrupts a neighbouring word or register. A read in the next request exposes that, because read data is combinational. Errors in the privilege or feature gating show up on `rsp_illegal` in the same cycle as the request, and by a register that changes when it should not.

// File: rtl/stateen_pkg.sv
`timescale 1ns/1ps
package stateen_pkg;
    localparam int NIDX = 4;
    localparam int DW   = 64;
    localparam int HW   = DW / 2;
    localparam int AW   = 12;
    localparam int IW   = $clog2(NIDX);

    typedef logic [DW-1:0]            word_t;
    typedef logic [NIDX-1:0][DW-1:0]  bank_t;

    localparam word_t ENABLE_BIT = word_t'(1) << (DW - 1);

    // privilege encodings
    localparam logic [1:0] PRV_U = 2'b00;
    localparam logic [1:0] PRV_S = 2'b01;
    localparam logic [1:0] PRV_M = 2'b11;

    // base addresses; index occupies addr[1:0]
    localparam logic [AW-1:0] A_M_LO = 12'h30C;
    localparam logic [AW-1:0] A_M_HI = 12'h31C;
    localparam logic [AW-1:0] A_H_LO = 12'h60C;
    localparam logic [AW-1:0] A_H_HI = 12'h61C;
    localparam logic [AW-1:0] A_S_LO = 12'h10C;

    typedef enum logic [1:0] {
        LVL_S    = 2'd0,
        LVL_H    = 2'd1,
        LVL_M    = 2'd2,
        LVL_NONE = 2'd3
    } lvl_e;

    typedef struct packed {
        logic          hit;
        lvl_e          lvl;
        logic          hi;
        logic [IW-1:0] idx;
    } dec_t;

    typedef struct packed {
        bank_t m;
        bank_t h;
        bank_t s;
    } state_t;
endpackage

// File: rtl/stateen_decode.sv
`timescale 1ns/1ps
module stateen_decode
    import stateen_pkg::*;
(
    input  logic [AW-1:0] addr,
    output dec_t          dec
);
    localparam int TAG = AW - IW;

    always_comb begin
        dec.hit = 1'b1;
        dec.lvl = LVL_NONE;
        dec.hi  = 1'b0;
        dec.idx = addr[IW-1:0];
        if (addr[AW-1:IW] == A_M_LO[AW-1:IW]) begin
            dec.lvl = LVL_M;
        end else if (addr[AW-1:IW] == A_M_HI[AW-1:IW]) begin
            dec.lvl = LVL_M;
            dec.hi  = 1'b1;
        end else if (addr[AW-1:IW] == A_H_LO[AW-1:IW]) begin
            dec.lvl = LVL_H;
        end else if (addr[AW-1:IW] == A_H_HI[AW-1:IW]) begin
            dec.lvl = LVL_H;
            dec.hi  = 1'b1;
        end else if (addr[AW-1:IW] == A_S_LO[AW-1:IW]) begin
            dec.lvl = LVL_S;
        end else begin
            dec.hit = 1'b0;
        end
    end

    logic [TAG-1:0] unused_tag;
    assign unused_tag = '0;
endmodule

// File: rtl/stateen_access.sv
`timescale 1ns/1ps
module stateen_access
    import stateen_pkg::*;
#(
    parameter bit IS_RV32 = 1'b0
)(
    input  lvl_e       lvl,
    input  logic       hi,
    input  logic       feat_en,
    input  logic [1:0] priv,
    input  logic       virt,
    output logic       allowed
);
    logic lvl_ok;
    logic half_ok;

    always_comb begin
        lvl_ok = 1'b0;
        case (lvl)
            LVL_M:   lvl_ok = (priv == PRV_M);
            LVL_H:   lvl_ok = (priv == PRV_M) || ((priv == PRV_S) && !virt);
            LVL_S:   lvl_ok = (priv == PRV_M) || (priv == PRV_S);
            default: lvl_ok = 1'b0;
        endcase
    end

    generate
        if (IS_RV32) begin : g_half32
            assign half_ok = 1'b1;
        end else begin : g_half64
            assign half_ok = !hi;
        end
    endgenerate

    assign allowed = feat_en && lvl_ok && half_ok;
endmodule

// File: rtl/stateen_regs.sv
`timescale 1ns/1ps
module stateen_regs
    import stateen_pkg::*;
#(
    parameter bit    IS_RV32 = 1'b0,
    parameter bank_t WMASK   = {NIDX{ENABLE_BIT}}
)(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  dec_t  dec,
    input  word_t wdata,
    input  logic  virt,
    output word_t rd_raw,
    output state_t st
);
    state_t st_d, st_q;
    word_t  old_w, merged_w, mask_w, next_w;

    // currently addressed word
    always_comb begin
        case (dec.lvl)
            LVL_M:   old_w = st_q.m[dec.idx];
            LVL_H:   old_w = st_q.h[dec.idx];
            LVL_S:   old_w = st_q.s[dec.idx];
            default: old_w = '0;
        endcase
    end

    // write data placed into the addressed half
    generate
        if (IS_RV32) begin : g_merge32
            always_comb begin
                if (dec.hi) merged_w = {wdata[HW-1:0], old_w[HW-1:0]};
                else        merged_w = {old_w[DW-1:HW], wdata[HW-1:0]};
            end
            always_comb begin
                if (dec.hi) rd_raw = {{HW{1'b0}}, old_w[DW-1:HW]};
                else        rd_raw = {{HW{1'b0}}, old_w[HW-1:0]};
            end
        end else begin : g_merge64
            assign merged_w = dec.hi ? {wdata[HW-1:0], old_w[HW-1:0]} : wdata;
            assign rd_raw   = dec.hi ? {{HW{1'b0}}, old_w[DW-1:HW]} : old_w;
        end
    endgenerate

    // mask inherited from the higher-level copies
    always_comb begin
        case (dec.lvl)
            LVL_M:   mask_w = WMASK[dec.idx];
            LVL_H:   mask_w = WMASK[dec.idx] & st_q.m[dec.idx];
            LVL_S:   mask_w = WMASK[dec.idx] & ~ENABLE_BIT & st_q.m[dec.idx]
                              & (virt ? st_q.h[dec.idx] : {DW{1'b1}});
            default: mask_w = '0;
        endcase
        next_w = (old_w & ~mask_w) | (merged_w & mask_w);
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (dec.lvl)
                LVL_M:   st_d.m[dec.idx] = next_w;
                LVL_H:   st_d.h[dec.idx] = next_w;
                LVL_S:   st_d.s[dec.idx] = next_w;
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/stateen_bank.sv
`timescale 1ns/1ps
module stateen_bank
    import stateen_pkg::*;
#(
    parameter bit    IS_RV32 = 1'b0,
    parameter bank_t WMASK   = {NIDX{ENABLE_BIT}}
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               feat_en,
    input  logic [1:0]         priv,
    input  logic               virt,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               rsp_hit,
    output logic               rsp_illegal,
    output logic [DW-1:0]      rsp_rdata,
    output logic [NIDX*DW-1:0] m_en,
    output logic [NIDX*DW-1:0] h_en,
    output logic [NIDX*DW-1:0] s_en
);
    dec_t   dec_w;
    logic   allowed_w;
    logic   wr_en_w;
    logic   hi_sel_w;
    word_t  rd_raw_w;
    state_t st_w;

    stateen_decode u_dec (
        .addr (req_addr),
        .dec  (dec_w)
    );

    stateen_access #(.IS_RV32(IS_RV32)) u_acc (
        .lvl     (dec_w.lvl),
        .hi      (dec_w.hi),
        .feat_en (feat_en),
        .priv    (priv),
        .virt    (virt),
        .allowed (allowed_w)
    );

    assign wr_en_w  = req_valid && req_write && dec_w.hit && allowed_w;
    assign hi_sel_w = dec_w.hit && dec_w.hi;

    stateen_regs #(.IS_RV32(IS_RV32), .WMASK(WMASK)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en_w),
        .dec    (dec_w),
        .wdata  (req_wdata),
        .virt   (virt),
        .rd_raw (rd_raw_w),
        .st     (st_w)
    );

    assign rsp_hit     = req_valid && dec_w.hit;
    assign rsp_illegal = req_valid && dec_w.hit && !allowed_w;
    assign rsp_rdata   = (req_valid && dec_w.hit && allowed_w) ? rd_raw_w : '0;
    assign m_en        = st_w.m;
    assign h_en        = st_w.h;
    assign s_en        = st_w.s;
endmodule

// File: rtl/stateen_bank_chk.sv
`timescale 1ns/1ps
module stateen_bank_chk
    import stateen_pkg::*;
#(
    parameter bit IS_RV32 = 1'b0
)(
    input logic               clk,
    input logic               rst_n,
    input logic               feat_en,
    input logic               req_valid,
    input logic               hit,
    input logic               hi_sel,
    input logic               illegal,
    input logic [NIDX*DW-1:0] m_en,
    input logic [NIDX*DW-1:0] h_en,
    input logic [NIDX*DW-1:0] s_en
);
    // R3: feature disabled makes every mapped access illegal
    a_r3_disabled_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && !feat_en) |-> illegal);

    // R11: an illegal access leaves every register unchanged
    a_r11_illegal_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> ($stable(m_en) && $stable(h_en) && $stable(s_en)));

    // R5: no request, no register change
    a_r5_idle_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(m_en) && $stable(h_en) && $stable(s_en)));

    generate
        if (!IS_RV32) begin : g_rv64
            // R10: upper-word addresses are rejected on a 64-bit core
            a_r10_high_half_rv64: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && hi_sel) |-> illegal);
        end
        for (genvar i = 0; i < NIDX; i++) begin : g_idx
            // R6: a hypervisor bit can newly set only under a set machine bit
            a_r6_h_needs_m: assert property (@(posedge clk) disable iff (!rst_n)
                (h_en[i*DW +: DW] & ~$past(h_en[i*DW +: DW]) & ~$past(m_en[i*DW +: DW])) == '0);
            // R7: a supervisor bit can newly set only under a set machine bit
            a_r7_s_needs_m: assert property (@(posedge clk) disable iff (!rst_n)
                (s_en[i*DW +: DW] & ~$past(s_en[i*DW +: DW]) & ~$past(m_en[i*DW +: DW])) == '0);
            // R7: the top bit of a supervisor copy stays clear
            a_r7_s_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
                !s_en[i*DW + DW - 1]);
        end
    endgenerate
endmodule

bind stateen_bank stateen_bank_chk #(.IS_RV32(IS_RV32)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .feat_en   (feat_en),
    .req_valid (req_valid),
    .hit       (dec_w.hit),
    .hi_sel    (hi_sel_w),
    .illegal   (rsp_illegal),
    .m_en      (m_en),
    .h_en      (h_en),
    .s_en      (s_en)
);

// File: tb/stateen_bank_tb.sv
`timescale 1ns/1ps
module stateen_bank_tb_top;
    import stateen_pkg::*;

    localparam bank_t TB_MASK = {
        64'hFFFF_FFFF_FFFF_FFFF,   // index 3
        64'hC000_0000_FFFF_0000,   // index 2
        64'h8000_0000_0000_00FF,   // index 1
        64'h8000_0000_0000_0000    // index 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        feat_en = 1'b0;
    logic [1:0]  priv = 2'b11;
    logic        virt = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;

    logic        hit32, ill32, hit64, ill64;
    logic [63:0] rd32, rd64;
    logic [255:0] m32, h32, s32, m64, h64, s64;

    // values captured during the last request
    logic        c_hit, c_ill, c_ill64;
    logic [63:0] c_rd, c_rd64;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    stateen_bank #(.IS_RV32(1'b1), .WMASK(TB_MASK)) dut_i (
        .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .priv(priv), .virt(virt),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_hit(hit32), .rsp_illegal(ill32),
        .rsp_rdata(rd32), .m_en(m32), .h_en(h32), .s_en(s32)
    );

    stateen_bank #(.IS_RV32(1'b0), .WMASK(TB_MASK)) dut64_i (
        .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .priv(priv), .virt(virt),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_hit(hit64), .rsp_illegal(ill64),
        .rsp_rdata(rd64), .m_en(m64), .h_en(h64), .s_en(s64)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic op(input logic w, input logic [11:0] a, input logic [63:0] d,
                      input logic [1:0] p, input logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        priv = p; virt = v;
        #1;
        c_hit = hit32; c_ill = ill32; c_rd = rd32;
        c_ill64 = ill64; c_rd64 = rd64;
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    function automatic logic [63:0] w32(input logic [255:0] v, input int i);
        return v[i*64 +: 64];
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) begin
            check("R2 m after reset", w32(m32, i), 64'h0);
            check("R2 h after reset", w32(h32, i), 64'h0);
            check("R2 s after reset", w32(s32, i), 64'h0);
        end
    endtask

    task automatic t_unmapped();
        op(1'b0, 12'h300, 64'h0, 2'b11, 1'b0);
        check("R1 unmapped hit", 64'(c_hit), 64'h0);
        check("R1 unmapped illegal", 64'(c_ill), 64'h0);
        check("R1 unmapped rdata", c_rd, 64'h0);
        op(1'b1, 12'h11F, 64'hFFFF_FFFF, 2'b11, 1'b0);
        check("R1 no supervisor upper word", 64'(c_hit), 64'h0);
    endtask

    task automatic t_feature_off();
        feat_en = 1'b0;
        op(1'b1, 12'h31C, 64'hFFFF_FFFF, 2'b11, 1'b0);
        check("R3 disabled illegal", 64'(c_ill), 64'h1);
        check("R3 disabled no write", w32(m32, 0), 64'h0);
        feat_en = 1'b1;
    endtask

    task automatic t_machine();
        op(1'b1, 12'h31D, 64'hFFFF_FFFF, 2'b11, 1'b0);
        check("R8 upper write m1", w32(m32, 1), 64'h8000_0000_0000_0000);
        op(1'b1, 12'h30D, 64'hFFFF_FFFF, 2'b11, 1'b0);
        check("R12 rdata shows pre-write value", c_rd, 64'h0);
        check("R5 masked write m1", w32(m32, 1), 64'h8000_0000_0000_00FF);
        op(1'b0, 12'h31D, 64'h0, 2'b11, 1'b0);
        check("R8 upper read m1", c_rd, 64'h0000_0000_8000_0000);
        op(1'b0, 12'h30D, 64'h0, 2'b11, 1'b0);
        check("R9 lower read m1", c_rd, 64'h0000_0000_0000_00FF);
        op(1'b1, 12'h31F, 64'h1234_5678, 2'b11, 1'b0);
        op(1'b1, 12'h30F, 64'h9ABC_DEF0, 2'b11, 1'b0);
        check("R1 index 3 assembled", w32(m32, 3), 64'h1234_5678_9ABC_DEF0);
        op(1'b1, 12'h30F, 64'h0, 2'b11, 1'b0);
        check("R9 lower write keeps upper", w32(m32, 3), 64'h1234_5678_0000_0000);
        check("R5 other index untouched", w32(m32, 2), 64'h0);
    endtask

    task automatic t_privilege();
        op(1'b1, 12'h30C, 64'hFFFF_FFFF, 2'b01, 1'b0);
        check("R4 S on machine copy", 64'(c_ill), 64'h1);
        op(1'b0, 12'h10C, 64'h0, 2'b00, 1'b0);
        check("R4 U on supervisor copy", 64'(c_ill), 64'h1);
        op(1'b0, 12'h60C, 64'h0, 2'b01, 1'b1);
        check("R4 VS on hypervisor copy", 64'(c_ill), 64'h1);
        op(1'b0, 12'h60D, 64'h0, 2'b01, 1'b0);
        check("R4 HS on hypervisor copy", 64'(c_ill), 64'h0);
        op(1'b0, 12'h10D, 64'h0, 2'b01, 1'b1);
        check("R4 VS on supervisor copy", 64'(c_ill), 64'h0);
    endtask

    task automatic t_illegal_noeffect();
        op(1'b1, 12'h30D, 64'h0, 2'b01, 1'b0);
        check("R11 illegal flagged", 64'(c_ill), 64'h1);
        check("R11 illegal rdata zero", c_rd, 64'h0);
        check("R11 illegal keeps m1", w32(m32, 1), 64'h8000_0000_0000_00FF);
    endtask

    task automatic t_hyp();
        op(1'b1, 12'h61D, 64'hFFFF_FFFF, 2'b11, 1'b0);
        op(1'b1, 12'h60D, 64'hFFFF_FFFF, 2'b11, 1'b0);
        check("R6 h1 limited by m1", w32(h32, 1), 64'h8000_0000_0000_00FF);
        op(1'b1, 12'h61E, 64'hFFFF_FFFF, 2'b11, 1'b0);
        op(1'b1, 12'h60E, 64'hFFFF_FFFF, 2'b11, 1'b0);
        check("R6 h2 blocked by zero m2", w32(h32, 2), 64'h0);
        op(1'b1, 12'h61F, 64'hFFFF_FFFF, 2'b11, 1'b0);
        op(1'b1, 12'h60F, 64'hFFFF_FFFF, 2'b11, 1'b0);
        check("R6 h3 follows m3", w32(h32, 3), 64'h1234_5678_0000_0000);
    endtask

    task automatic t_sup();
        op(1'b1, 12'h30F, 64'h0000_FFFF, 2'b11, 1'b0);
        check("R5 m3 low update", w32(m32, 3), 64'h1234_5678_0000_FFFF);
        op(1'b1, 12'h10F, 64'hFFFF_FFFF, 2'b01, 1'b0);
        check("R7 s3 non-virt uses m3", w32(s32, 3), 64'h0000_0000_0000_FFFF);
        op(1'b1, 12'h10F, 64'h0, 2'b01, 1'b0);
        check("R7 s3 cleared", w32(s32, 3), 64'h0);
        op(1'b1, 12'h10F, 64'hFFFF_FFFF, 2'b01, 1'b1);
        check("R7 s3 virt blocked by h3", w32(s32, 3), 64'h0);
        op(1'b1, 12'h60F, 64'h0000_00F0, 2'b11, 1'b0);
        check("R6 h3 low update", w32(h32, 3), 64'h1234_5678_0000_00F0);
        op(1'b1, 12'h10F, 64'hFFFF_FFFF, 2'b01, 1'b1);
        check("R7 s3 virt uses m3 and h3", w32(s32, 3), 64'h0000_0000_0000_00F0);
        op(1'b0, 12'h10F, 64'h0, 2'b01, 1'b1);
        check("R12 s3 read", c_rd, 64'h0000_0000_0000_00F0);
    endtask

    task automatic t_rv64();
        do_reset();
        check("R2 rv64 reset", w32(m64, 3), 64'h0);
        op(1'b1, 12'h30F, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b0);
        check("R9 rv64 full write", w32(m64, 3), 64'hFFFF_FFFF_FFFF_FFFF);
        op(1'b1, 12'h31F, 64'h0, 2'b11, 1'b0);
        check("R10 rv64 upper illegal", 64'(c_ill64), 64'h1);
        check("R10 rv64 upper no write", w32(m64, 3), 64'hFFFF_FFFF_FFFF_FFFF);
        op(1'b1, 12'h60F, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b0);
        op(1'b1, 12'h10F, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01, 1'b0);
        check("R7 rv64 s3 top bit clear", w32(s64, 3), 64'h7FFF_FFFF_FFFF_FFFF);
        op(1'b0, 12'h30F, 64'h0, 2'b11, 1'b0);
        check("R9 rv64 full read", c_rd64, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        t_reset();
        feat_en = 1'b1;
        t_unmapped();
        t_feature_off();
        t_machine();
        t_privilege();
        t_illegal_noeffect();
        t_hyp();
        t_sup();
        t_rv64();
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule